// File: doc/BRIEF.md
# SPI Target Command Decoder

This block sits behind a byte-wide SPI shift interface on the target side of a host link. It takes command frames one byte at a time through a valid/ready handshake. It decodes the opcode that leads each frame and gathers the address, length and data fields that follow. When checking is enabled, it also verifies a trailing CRC7 byte. It then acts on the command. Register accesses become single-cycle read or write strobes toward the register space. DMA commands become a single-cycle length request toward a separate data framer. A small protocol-control register, held inside the block, decides whether CRC checking is active.

Every command that is not a reset gets a response through an output valid/ready byte stream. The response starts with the echoed opcode and a status byte. A successful read then adds a header byte, the 32-bit word and, while CRC is enabled, a two-byte trailer. External registers use a 24-bit address. Internal registers use a 16-bit address field whose top bit marks a clockless access. The protocol-control register can turn CRC off at run time. After that, frames are sent without the CRC byte and read responses are sent without the trailer.

Top module: `spi_cmd_decoder`

## Requirements
- R1: After reset `rxReady` is 1, `txValid` is 0, no strobe is active and `crcEnabled` is 1.
- R2: While CRC is enabled, every command frame ends with one check byte `{crc7,1'b0}`. The CRC7 uses the polynomial x^7+x^3+1, starts at 7'h7F, is processed MSB first and covers the opcode and all field bytes. On a mismatch the status is 8'h02 and no strobe or register change occurs.
- R3: Opcode 8'hC9 (single write) is followed by a 24-bit address and then a 32-bit word, each most significant byte first. It raises `regWrEn` for one cycle with `regInternal`=0 and returns the two bytes {8'hC9, 8'h00}.
- R4: Opcode 8'hCA (single read) carries a 24-bit address, MSB first. It raises `regRdEn` once and returns {8'hCA, 8'h00, 8'hF0, word MSB first}. While CRC is enabled, two 8'h00 trailer bytes follow.
- R5: Opcode 8'hC3 (internal write) carries a 16-bit address followed by a 32-bit word. Opcode 8'hC4 (internal read) carries a 16-bit address and one pad byte. For both, bit 7 of the first address byte drives `regClockless`, `regAddr` is the low 15 address bits and `regInternal` is 1. The responses have the same shape as in R3 and R4, with the opcode echoed.
- R6: Opcodes 8'hC1 and 8'hC2 carry a 24-bit address and a 16-bit length. Opcodes 8'hC7 and 8'hC8 carry a 24-bit address and a 24-bit length. All fields are MSB first. Each of these commands pulses `dmaReqValid` once, with `dmaWrite`=1 for 8'hC1 and 8'hC7 only, and returns {opcode, 8'h00}.
- R7: The internal address 15'h0024 selects the protocol-control register, whose reset value is 32'h0000002C. Accesses to it raise no register strobe. Reads return its value. CRC is enabled while bits 3:2 are not both zero. While CRC is disabled, frames carry no check byte and read responses carry no trailer.
- R8: An opcode outside the defined set is answered at once with {opcode, 8'h01}, without waiting for further bytes and without any strobe.
- R9: Opcode 8'hCF is consumed on its own. No response is sent and the decoder stays ready for a new opcode.
- R10: Opcodes 8'hC5 and 8'hC6 carry three ignored bytes and return {opcode, 8'h00} with no strobe.
- R11: While `txValid` is 1 and `txReady` is 0, `txValid` and `txData` hold their values. Input and output never handshake in the same cycle.
- R12: Every accepted command raises at most one of `regWrEn`, `regRdEn` and `dmaReqValid`, for exactly one cycle. That cycle falls between the last frame byte and the first response byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Command byte available |
| rxData | input | 8 | Command byte |
| rxReady | output | 1 | Decoder accepts a command byte |
| txValid | output | 1 | Response byte available |
| txData | output | 8 | Response byte |
| txReady | input | 1 | Consumer takes the response byte |
| regWrEn | output | 1 | One-cycle register write strobe |
| regRdEn | output | 1 | One-cycle register read strobe |
| regInternal | output | 1 | Access targets the internal register space |
| regClockless | output | 1 | Internal access flagged as clockless |
| regAddr | output | 24 | Register address, valid with a strobe |
| regWrData | output | 32 | Write word, valid with `regWrEn` |
| regRdData | input | 32 | Read word, valid in the `regRdEn` cycle |
| dmaReqValid | output | 1 | One-cycle DMA request to the data framer |
| dmaWrite | output | 1 | DMA direction, 1 for host-to-target |
| dmaAddr | output | 24 | DMA start address |
| dmaLen | output | 24 | DMA length in bytes |
| crcEnabled | output | 1 | Command CRC checking is active |

## Verification
The bound checker watches four things on every cycle: response bytes stay stable during a stall, input and output handshakes never overlap, the side-effect strobes are mutually exclusive and each is followed directly by a response, and the first response byte echoes the opcode that was accepted. It also confirms that a reset opcode produces no response. The field positions, the CRC arithmetic, the status codes, the trailer that depends on the protocol register, and the rule that a bad CRC or unknown opcode leaves registers alone are shown only by the bench. The bench sweeps every undefined opcode, walks a one through each address bit and turns CRC off and back on through the protocol register.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int BYTE_W      = 8;
  localparam int ADDR_W      = 24;
  localparam int WORD_W      = 32;
  localparam int IADDR_W     = 15;
  localparam int MAX_PAYLOAD = 7;
  localparam int BUF_W       = MAX_PAYLOAD * BYTE_W;
  localparam int CNT_W       = $clog2(MAX_PAYLOAD + 1);
  localparam int IDX_W       = 4;

  localparam logic [7:0] OP_DMA_WR   = 8'hC1;
  localparam logic [7:0] OP_DMA_RD   = 8'hC2;
  localparam logic [7:0] OP_INT_WR   = 8'hC3;
  localparam logic [7:0] OP_INT_RD   = 8'hC4;
  localparam logic [7:0] OP_TERM     = 8'hC5;
  localparam logic [7:0] OP_REPEAT   = 8'hC6;
  localparam logic [7:0] OP_XDMA_WR  = 8'hC7;
  localparam logic [7:0] OP_XDMA_RD  = 8'hC8;
  localparam logic [7:0] OP_SGL_WR   = 8'hC9;
  localparam logic [7:0] OP_SGL_RD   = 8'hCA;
  localparam logic [7:0] OP_RESET    = 8'hCF;

  localparam logic [7:0] ST_OK       = 8'h00;
  localparam logic [7:0] ST_BAD_OP   = 8'h01;
  localparam logic [7:0] ST_BAD_CRC  = 8'h02;
  localparam logic [7:0] RD_HEADER   = 8'hF0;
  localparam logic [7:0] TRAILER     = 8'h00;
  localparam logic [6:0] CRC_SEED    = 7'h7F;
  localparam logic [6:0] CRC_POLY    = 7'h09;

  typedef struct packed {
    logic loadOp;
    logic shiftIn;
    logic checkCrc;
    logic execute;
  } strobe_t;

  function automatic logic opKnown(input logic [7:0] op);
    case (op)
      OP_DMA_WR, OP_DMA_RD, OP_INT_WR, OP_INT_RD, OP_TERM, OP_REPEAT,
      OP_XDMA_WR, OP_XDMA_RD, OP_SGL_WR, OP_SGL_RD: opKnown = 1'b1;
      default: opKnown = 1'b0;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] opPayload(input logic [7:0] op);
    case (op)
      OP_DMA_WR, OP_DMA_RD:   opPayload = CNT_W'(5);
      OP_INT_WR:              opPayload = CNT_W'(6);
      OP_XDMA_WR, OP_XDMA_RD: opPayload = CNT_W'(6);
      OP_SGL_WR:              opPayload = CNT_W'(7);
      default:                opPayload = CNT_W'(3);
    endcase
  endfunction

  function automatic logic [6:0] crc7Step(input logic [6:0] crcIn,
                                          input logic [7:0] data);
    logic [6:0] c;
    logic fb;
    c = crcIn;
    for (int i = 7; i >= 0; i--) begin
      fb = c[6] ^ data[i];
      c = {c[5:0], 1'b0} ^ (fb ? CRC_POLY : 7'h00);
    end
    return c;
  endfunction

endpackage

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic [7:0]       rxData,
  input  logic             txReady,
  input  logic             crcEn,
  input  logic [IDX_W-1:0] respLen,
  output logic             rxReady,
  output logic             txValid,
  output logic [IDX_W-1:0] txIdx,
  output strobe_t          stb
);

  typedef enum logic [2:0] {
    S_IDLE, S_PAYLOAD, S_CRC, S_EXEC, S_RESP
  } state_e;

  state_e           state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic [IDX_W-1:0] idxNxt;

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    idxNxt   = txIdx;
    stb      = '0;
    rxReady  = 1'b0;
    txValid  = 1'b0;
    case (state)
      S_IDLE: begin
        rxReady = 1'b1;
        if (rxValid && rxData != OP_RESET) begin
          stb.loadOp = 1'b1;
          if (opKnown(rxData)) begin
            cntNxt   = opPayload(rxData);
            stateNxt = S_PAYLOAD;
          end else begin
            stateNxt = S_EXEC;
          end
        end
      end
      S_PAYLOAD: begin
        rxReady = 1'b1;
        if (rxValid) begin
          stb.shiftIn = 1'b1;
          cntNxt      = cnt - CNT_W'(1);
          if (cnt == CNT_W'(1)) stateNxt = crcEn ? S_CRC : S_EXEC;
        end
      end
      S_CRC: begin
        rxReady = 1'b1;
        if (rxValid) begin
          stb.checkCrc = 1'b1;
          stateNxt     = S_EXEC;
        end
      end
      S_EXEC: begin
        stb.execute = 1'b1;
        idxNxt      = '0;
        stateNxt    = S_RESP;
      end
      S_RESP: begin
        txValid = 1'b1;
        if (txReady) begin
          if (txIdx == respLen - IDX_W'(1)) stateNxt = S_IDLE;
          else idxNxt = txIdx + IDX_W'(1);
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      txIdx <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
      txIdx <= idxNxt;
    end
  end

endmodule

// File: rtl/spi_cmd_dp.sv
module spi_cmd_dp
  import spi_cmd_pkg::*;
#(
  parameter logic [IADDR_W-1:0] PROTO_ADDR  = 15'h0024,
  parameter logic [WORD_W-1:0]  PROTO_RESET = 32'h0000_002C
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [7:0]        rxData,
  input  logic [IDX_W-1:0]  txIdx,
  output logic [7:0]        txData,
  output logic [IDX_W-1:0]  respLen,
  output logic              crcEn,
  output logic              regWrEn,
  output logic              regRdEn,
  output logic              regInternal,
  output logic              regClockless,
  output logic [ADDR_W-1:0] regAddr,
  output logic [WORD_W-1:0] regWrData,
  input  logic [WORD_W-1:0] regRdData,
  output logic              dmaReqValid,
  output logic              dmaWrite,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic [ADDR_W-1:0] dmaLen
);

  localparam int ZPAD = ADDR_W - IADDR_W;

  logic [7:0]        opReg;
  logic [BUF_W-1:0]  fieldBuf;
  logic [6:0]        crcAcc;
  logic              crcBad;
  logic              opBad;
  logic [7:0]        statusReg;
  logic [WORD_W-1:0] rdWord;
  logic [WORD_W-1:0] protoReg;

  logic isSglWr, isSglRd, isIntWr, isIntRd, isDma, isDmaExt, isRead;
  logic [15:0]        intField;
  logic [IADDR_W-1:0] intAddr;
  logic               protoHit, cmdOk;

  always_comb begin
    isSglWr  = opReg == OP_SGL_WR;
    isSglRd  = opReg == OP_SGL_RD;
    isIntWr  = opReg == OP_INT_WR;
    isIntRd  = opReg == OP_INT_RD;
    isDmaExt = opReg == OP_XDMA_WR || opReg == OP_XDMA_RD;
    isDma    = isDmaExt || opReg == OP_DMA_WR || opReg == OP_DMA_RD;
    isRead   = isSglRd || isIntRd;
    dmaWrite = opReg == OP_DMA_WR || opReg == OP_XDMA_WR;
    intField = isIntWr ? fieldBuf[47:32] : fieldBuf[23:8];
    intAddr  = intField[IADDR_W-1:0];
    regInternal  = isIntWr || isIntRd;
    regClockless = regInternal && intField[15];
    protoHit = regInternal && intAddr == PROTO_ADDR;
    cmdOk    = !opBad && !crcBad;
    crcEn    = |protoReg[3:2];
    regAddr  = regInternal ? {{ZPAD{1'b0}}, intAddr}
                           : (isSglWr ? fieldBuf[55:32] : fieldBuf[23:0]);
    regWrData = fieldBuf[31:0];
    dmaAddr  = isDmaExt ? fieldBuf[47:24] : fieldBuf[39:16];
    dmaLen   = isDmaExt ? fieldBuf[23:0] : {8'h00, fieldBuf[15:0]};
    regWrEn  = stb.execute && cmdOk && (isSglWr || (isIntWr && !protoHit));
    regRdEn  = stb.execute && cmdOk && (isSglRd || (isIntRd && !protoHit));
    dmaReqValid = stb.execute && cmdOk && isDma;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg    <= '0;
      fieldBuf <= '0;
      crcAcc   <= CRC_SEED;
      crcBad   <= 1'b0;
      opBad    <= 1'b0;
    end else begin
      if (stb.loadOp) begin
        opReg  <= rxData;
        opBad  <= !opKnown(rxData);
        crcAcc <= crc7Step(CRC_SEED, rxData);
        crcBad <= 1'b0;
      end
      if (stb.shiftIn) begin
        fieldBuf <= {fieldBuf[BUF_W-9:0], rxData};
        crcAcc   <= crc7Step(crcAcc, rxData);
      end
      if (stb.checkCrc) crcBad <= rxData != {crcAcc, 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusReg <= ST_OK;
      rdWord    <= '0;
      respLen   <= IDX_W'(2);
      protoReg  <= PROTO_RESET;
    end else if (stb.execute) begin
      statusReg <= opBad ? ST_BAD_OP : (crcBad ? ST_BAD_CRC : ST_OK);
      rdWord    <= protoHit ? protoReg : regRdData;
      respLen   <= (cmdOk && isRead) ? (crcEn ? IDX_W'(9) : IDX_W'(7))
                                     : IDX_W'(2);
      if (cmdOk && isIntWr && protoHit) protoReg <= fieldBuf[31:0];
    end
  end

  always_comb begin
    case (txIdx)
      IDX_W'(0): txData = opReg;
      IDX_W'(1): txData = statusReg;
      IDX_W'(2): txData = RD_HEADER;
      IDX_W'(3): txData = rdWord[31:24];
      IDX_W'(4): txData = rdWord[23:16];
      IDX_W'(5): txData = rdWord[15:8];
      IDX_W'(6): txData = rdWord[7:0];
      default:   txData = TRAILER;
    endcase
  end

endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
  import spi_cmd_pkg::*;
#(
  parameter logic [IADDR_W-1:0] PROTO_ADDR  = 15'h0024,
  parameter logic [WORD_W-1:0]  PROTO_RESET = 32'h0000_002C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  output logic              rxReady,
  output logic              txValid,
  output logic [7:0]        txData,
  input  logic              txReady,
  output logic              regWrEn,
  output logic              regRdEn,
  output logic              regInternal,
  output logic              regClockless,
  output logic [ADDR_W-1:0] regAddr,
  output logic [WORD_W-1:0] regWrData,
  input  logic [WORD_W-1:0] regRdData,
  output logic              dmaReqValid,
  output logic              dmaWrite,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic [ADDR_W-1:0] dmaLen,
  output logic              crcEnabled
);

  strobe_t          stb;
  logic [IDX_W-1:0] txIdx;
  logic [IDX_W-1:0] respLen;

  spi_cmd_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rxValid (rxValid),
    .rxData  (rxData),
    .txReady (txReady),
    .crcEn   (crcEnabled),
    .respLen (respLen),
    .rxReady (rxReady),
    .txValid (txValid),
    .txIdx   (txIdx),
    .stb     (stb)
  );

  spi_cmd_dp #(
    .PROTO_ADDR  (PROTO_ADDR),
    .PROTO_RESET (PROTO_RESET)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .rxData       (rxData),
    .txIdx        (txIdx),
    .txData       (txData),
    .respLen      (respLen),
    .crcEn        (crcEnabled),
    .regWrEn      (regWrEn),
    .regRdEn      (regRdEn),
    .regInternal  (regInternal),
    .regClockless (regClockless),
    .regAddr      (regAddr),
    .regWrData    (regWrData),
    .regRdData    (regRdData),
    .dmaReqValid  (dmaReqValid),
    .dmaWrite     (dmaWrite),
    .dmaAddr      (dmaAddr),
    .dmaLen       (dmaLen)
  );

endmodule

// File: rtl/spi_cmd_decoder_chk.sv
module spi_cmd_decoder_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rxValid,
  input logic [7:0] rxData,
  input logic       rxReady,
  input logic       txValid,
  input logic [7:0] txData,
  input logic       txReady,
  input logic       regWrEn,
  input logic       regRdEn,
  input logic       dmaReqValid
);

  logic       awaitOp;
  logic       echoDue;
  logic [7:0] opSeen;
  logic       rxHs, txHs;

  assign rxHs = rxValid && rxReady;
  assign txHs = txValid && txReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      awaitOp <= 1'b1;
      echoDue <= 1'b0;
      opSeen  <= '0;
    end else begin
      if (rxHs && awaitOp && rxData != 8'hCF) begin
        opSeen  <= rxData;
        awaitOp <= 1'b0;
        echoDue <= 1'b1;
      end
      if (txHs) begin
        echoDue <= 1'b0;
        awaitOp <= 1'b1;
      end
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txData)); // R11

  AST_NO_HS_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(rxReady && txValid)); // R11

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regWrEn, regRdEn, dmaReqValid})); // R12

  AST_STROBE_THEN_RESP: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn || regRdEn || dmaReqValid) |=> txValid && !rxReady); // R12

  AST_ECHO_OPCODE: assert property (@(posedge clk) disable iff (!rstN)
    txValid && echoDue |-> txData == opSeen); // R8

  AST_RESET_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    rxHs && awaitOp && rxData == 8'hCF |=> rxReady && !txValid); // R9

endmodule

bind spi_cmd_decoder spi_cmd_decoder_chk u_chk (.*);

// File: tb/tb_spi_cmd_decoder.sv
`timescale 1ns/1ps
module tb_spi_cmd_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxReady;
  logic        txValid;
  logic [7:0]  txData;
  logic        txReady = 1'b0;
  logic        regWrEn, regRdEn, regInternal, regClockless;
  logic [23:0] regAddr;
  logic [31:0] regWrData, regRdData;
  logic        dmaReqValid, dmaWrite;
  logic [23:0] dmaAddr, dmaLen;
  logic        crcEnabled;

  always #2.5 clk = ~clk;

  spi_cmd_decoder dut (.*);

  function automatic logic [31:0] rdModel(input logic [23:0] a);
    return {a[7:0], a} ^ 32'h5A3C_96E1;
  endfunction
  assign regRdData = rdModel(regAddr);

  int wrCnt = 0, rdCnt = 0, dmaCnt = 0;
  logic [23:0] wrAddr, rdAddr, dAddr, dLen;
  logic [31:0] wrData;
  logic wrInt, wrClk, rdInt, rdClk, dWr;
  always @(posedge clk) if (rstN) begin
    if (regWrEn) begin
      wrCnt <= wrCnt + 1; wrAddr <= regAddr; wrData <= regWrData;
      wrInt <= regInternal; wrClk <= regClockless;
    end
    if (regRdEn) begin
      rdCnt <= rdCnt + 1; rdAddr <= regAddr;
      rdInt <= regInternal; rdClk <= regClockless;
    end
    if (dmaReqValid) begin
      dmaCnt <= dmaCnt + 1; dAddr <= dmaAddr; dLen <= dmaLen; dWr <= dmaWrite;
    end
  end

  int total = 0, fails = 0;
  bit crcOn = 1'b1;
  logic [7:0] fr [0:7];
  logic [7:0] ex [0:8];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] refCrc(input int n);
    int r = 7'h7F;
    for (int k = 0; k < n; k++)
      for (int b = 7; b >= 0; b--) begin
        int top = ((r >> 6) & 1) ^ ((fr[k] >> b) & 1);
        r = ((r << 1) & 7'h7F) ^ (top * 9);
      end
    return r[6:0];
  endfunction

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxData = b;
    while (!rxReady) @(negedge clk);
    @(posedge clk); #1;
    rxValid = 1'b0;
  endtask

  task automatic sendFrame(input int n, input bit corrupt);
    logic [7:0] c;
    for (int i = 0; i < n; i++) sendByte(fr[i]);
    c = {refCrc(n), 1'b0};
    if (corrupt) c = c ^ 8'h02;
    if (crcOn) sendByte(c);
  endtask

  task automatic recvByte(output logic [7:0] b);
    @(negedge clk);
    txReady = 1'b1;
    while (!txValid) @(negedge clk);
    b = txData;
    @(posedge clk); #1;
    txReady = 1'b0;
  endtask

  task automatic expectResp(input int n, input string req);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      recvByte(b);
      chk(req, b, ex[i]);
    end
    @(negedge clk);
    chk(req, txValid, 0);
  endtask

  task automatic setReadResp(input logic [7:0] op, input logic [31:0] w);
    ex[0] = op; ex[1] = 8'h00; ex[2] = 8'hF0;
    ex[3] = w[31:24]; ex[4] = w[23:16]; ex[5] = w[15:8]; ex[6] = w[7:0];
    ex[7] = 8'h00; ex[8] = 8'h00;
  endtask

  bit done = 1'b0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int w0, r0, d0;
    logic [7:0] hold;
    repeat (4) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 rxReady", rxReady, 1);
    chk("R1 txValid", txValid, 0);
    chk("R1 strobes", {regWrEn, regRdEn, dmaReqValid}, 0);
    chk("R1 crcEnabled", crcEnabled, 1);

    // R3 single write
    fr[0]=8'hC9; fr[1]=8'h12; fr[2]=8'h34; fr[3]=8'h56;
    fr[4]=8'hDE; fr[5]=8'hAD; fr[6]=8'hBE; fr[7]=8'hEF;
    sendFrame(8, 0);
    ex[0]=8'hC9; ex[1]=8'h00; expectResp(2, "R3 resp");
    chk("R3 wrCnt R12", wrCnt, 1);
    chk("R3 addr", wrAddr, 24'h123456);
    chk("R3 data", wrData, 32'hDEADBEEF);
    chk("R3 internal", wrInt, 0);

    // R4 walking-one address sweep for single read
    for (int bit_i = 0; bit_i < 24; bit_i++) begin
      logic [23:0] a = 24'h1 << bit_i;
      r0 = rdCnt;
      fr[0]=8'hCA; fr[1]=a[23:16]; fr[2]=a[15:8]; fr[3]=a[7:0];
      sendFrame(4, 0);
      setReadResp(8'hCA, rdModel(a));
      expectResp(9, "R4 read resp");
      chk("R4 read addr", rdAddr, a);
      chk("R12 one read strobe", rdCnt - r0, 1);
    end

    // R5 internal write, clockless flag set
    fr[0]=8'hC3; fr[1]=8'h81; fr[2]=8'h23;
    fr[3]=8'h01; fr[4]=8'h02; fr[5]=8'h03; fr[6]=8'h04;
    sendFrame(7, 0);
    ex[0]=8'hC3; ex[1]=8'h00; expectResp(2, "R5 iwr resp");
    chk("R5 iwr addr", wrAddr, 24'h000123);
    chk("R5 iwr data", wrData, 32'h01020304);
    chk("R5 iwr internal", wrInt, 1);
    chk("R5 iwr clockless", wrClk, 1);

    // R5 internal read, no flag, pad byte
    fr[0]=8'hC4; fr[1]=8'h00; fr[2]=8'h42; fr[3]=8'h00;
    sendFrame(4, 0);
    setReadResp(8'hC4, rdModel(24'h000042));
    expectResp(9, "R5 ird resp");
    chk("R5 ird addr", rdAddr, 24'h000042);
    chk("R5 ird internal", rdInt, 1);
    chk("R5 ird clockless", rdClk, 0);

    // R6 DMA commands
    for (int k = 0; k < 4; k++) begin
      logic [7:0] op;
      bit ext;
      op = (k == 0) ? 8'hC1 : (k == 1) ? 8'hC2 : (k == 2) ? 8'hC7 : 8'hC8;
      ext = k >= 2;
      d0 = dmaCnt;
      fr[0]=op; fr[1]=8'h01; fr[2]=8'h02; fr[3]=8'h03 + 8'(k);
      if (ext) begin fr[4]=8'h01; fr[5]=8'h23; fr[6]=8'h45; sendFrame(7, 0); end
      else begin fr[4]=8'h04; fr[5]=8'h00; sendFrame(6, 0); end
      ex[0]=op; ex[1]=8'h00; expectResp(2, "R6 dma resp");
      chk("R6 dma count R12", dmaCnt - d0, 1);
      chk("R6 dma addr", dAddr, 24'h010203 + 24'(k));
      chk("R6 dma len", dLen, ext ? 24'h012345 : 24'h000400);
      chk("R6 dma dir", dWr, (k == 0 || k == 2) ? 1 : 0);
    end

    // R10 terminate / repeat
    for (int k = 0; k < 2; k++) begin
      w0 = wrCnt; r0 = rdCnt; d0 = dmaCnt;
      fr[0] = (k == 0) ? 8'hC5 : 8'hC6; fr[1]=8'hAA; fr[2]=8'hBB; fr[3]=8'hCC;
      sendFrame(4, 0);
      ex[0]=fr[0]; ex[1]=8'h00; expectResp(2, "R10 resp");
      chk("R10 no strobe", (wrCnt-w0)+(rdCnt-r0)+(dmaCnt-d0), 0);
    end

    // R2 corrupted CRC
    w0 = wrCnt;
    fr[0]=8'hC9; fr[1]=8'h00; fr[2]=8'h00; fr[3]=8'h10;
    fr[4]=8'h11; fr[5]=8'h22; fr[6]=8'h33; fr[7]=8'h44;
    sendFrame(8, 1);
    ex[0]=8'hC9; ex[1]=8'h02; expectResp(2, "R2 bad crc resp");
    chk("R2 bad crc no write", wrCnt - w0, 0);

    // R9 reset opcode
    sendByte(8'hCF);
    repeat (3) @(negedge clk);
    chk("R9 no response", txValid, 0);
    chk("R9 ready", rxReady, 1);

    // R11 stall during response
    fr[0]=8'hCA; fr[1]=8'h00; fr[2]=8'h77; fr[3]=8'h88;
    sendFrame(4, 0);
    @(negedge clk);
    while (!txValid) @(negedge clk);
    hold = txData;
    repeat (4) @(negedge clk);
    chk("R11 valid held", txValid, 1);
    chk("R11 data held", txData, hold);
    chk("R11 rx blocked", rxReady, 0);
    setReadResp(8'hCA, rdModel(24'h007788));
    expectResp(9, "R11 resp after stall");

    // R7 protocol register read
    r0 = rdCnt;
    fr[0]=8'hC4; fr[1]=8'h00; fr[2]=8'h24; fr[3]=8'h00;
    sendFrame(4, 0);
    setReadResp(8'hC4, 32'h0000002C);
    expectResp(9, "R7 proto read");
    chk("R7 no rd strobe", rdCnt - r0, 0);

    // R7 disable CRC
    w0 = wrCnt;
    fr[0]=8'hC3; fr[1]=8'h00; fr[2]=8'h24;
    fr[3]=8'h00; fr[4]=8'h00; fr[5]=8'h00; fr[6]=8'h50;
    sendFrame(7, 0);
    ex[0]=8'hC3; ex[1]=8'h00; expectResp(2, "R7 proto write");
    crcOn = 1'b0;
    chk("R7 no wr strobe", wrCnt - w0, 0);
    chk("R7 crc off", crcEnabled, 0);
    fr[0]=8'hCA; fr[1]=8'hAB; fr[2]=8'hCD; fr[3]=8'hEF;
    sendFrame(4, 0);
    setReadResp(8'hCA, rdModel(24'hABCDEF));
    expectResp(7, "R7 no trailer");
    fr[0]=8'hC1; fr[1]=8'h00; fr[2]=8'h00; fr[3]=8'h40; fr[4]=8'h00; fr[5]=8'h08;
    sendFrame(6, 0);
    ex[0]=8'hC1; ex[1]=8'h00; expectResp(2, "R7 dma no crc");
    chk("R7 dma len no crc", dLen, 24'h000008);
    // re-enable
    fr[0]=8'hC3; fr[1]=8'h00; fr[2]=8'h24;
    fr[3]=8'h00; fr[4]=8'h00; fr[5]=8'h00; fr[6]=8'h2C;
    sendFrame(7, 0);
    ex[0]=8'hC3; ex[1]=8'h00; expectResp(2, "R7 re-enable");
    crcOn = 1'b1;
    chk("R7 crc on", crcEnabled, 1);

    // R8 sweep of undefined opcodes
    w0 = wrCnt; r0 = rdCnt; d0 = dmaCnt;
    for (int op = 0; op < 256; op++) begin
      if ((op >= 8'hC1 && op <= 8'hCA) || op == 8'hCF) continue;
      sendByte(8'(op));
      ex[0] = 8'(op); ex[1] = 8'h01;
      expectResp(2, "R8 unknown op");
    end
    chk("R8 no strobes", (wrCnt-w0)+(rdCnt-r0)+(dmaCnt-d0), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule